// File: doc/BRIEF.md
# Predicated Vector Register Move Sequencer

This block carries out one register move over a 32-entry, 32-bit register file. Each of the two operands is marked scalar or vector. A vector operand covers the registers from its start register up to start + VL - 1. A scalar operand always names the same single register. Each side may also carry an 8-bit predicate mask. The scalar/vector marks and the presence of each mask are enough to turn the one move into several operations:

- broadcast (splat) and sparse broadcast
- single-element insert and extract
- straight copy
- packing gather
- spreading scatter
- combined gather/scatter

The sequencer keeps a source cursor and a destination cursor, and each one steps over clear predicate bits on its own. In each cycle it issues at most one register-file read and one write. The write data is the value read in that same cycle. The register file sits outside the block and returns read data combinationally. A start pulse latches the request. When the move is over, a one-cycle done pulse follows.

Top module: `vmove_seq`

## Requirements
- R1: After reset, and whenever no move is running, `done`, `rf_re` and `rf_we` are low.
- R2: With a scalar source and a vector destination, when the destination mask is not enabled, the source register is written into every destination element 0..VL-1. The move takes exactly VL cycles, so `done` is high on the (VL+1)-th cycle after the start cycle.
- R3: With a scalar source, a vector destination and the destination mask enabled, only the destination elements whose mask bit is 1 receive the scalar. A mask with a single 1 bit inserts the value into that one element. An all-zero mask writes nothing.
- R4: With a vector source and a scalar destination, the scalar receives the first source element whose mask bit is 1. If the source mask is not enabled, it receives element 0. The destination is written at most once, and it is not written at all when the enabled mask is zero.
- R5: With two vector operands and neither mask enabled, source element i is copied to destination element i for every i below VL. The move takes exactly VL cycles.
- R6: With two vector operands and only the source mask enabled, the source elements whose bit is 1 are packed in ascending order into destination elements 0, 1, 2 and so on.
- R7: With two vector operands and only the destination mask enabled, consecutive source elements go in ascending order to the destination elements whose bit is 1. With both masks enabled, the k-th selected source element goes to the k-th selected destination element. In either case the move stops as soon as either cursor passes element VL-1.
- R8: Element i of a vector operand is register (start + i) mod 32. Mask bit i belongs to element i.
- R9: A VL input of 0 acts as 1. A VL input above 8 acts as 8.
- R10: `done` is high for exactly one cycle per move. While a move is running, `start` and every request input are ignored.
- R11: No write reaches an element whose mask bit is 0. The number of writes equals the number of source/destination pairs that R2 to R7 and R12 define. Within one move, no element is read twice and no element is written twice.
- R12: The mask of a scalar operand is ignored. A scalar-to-scalar move copies the source register to the destination register once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a move when the block is idle |
| src_base | input | 5 | Source start register |
| dst_base | input | 5 | Destination start register |
| src_vec | input | 1 | 1: source is a vector, 0: scalar |
| dst_vec | input | 1 | 1: destination is a vector, 0: scalar |
| src_pred_en | input | 1 | Enables the source mask |
| src_pred | input | 8 | Source mask, bit i for element i |
| dst_pred_en | input | 1 | Enables the destination mask |
| dst_pred | input | 8 | Destination mask, bit i for element i |
| vl | input | 4 | Vector length request |
| rf_re | output | 1 | Register-file read strobe |
| rf_raddr | output | 5 | Read address |
| rf_rdata | input | 32 | Read data, returned in the same cycle |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 5 | Write address |
| rf_wdata | output | 32 | Write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
A cursor stuck on one element, or one that fails to skip a clear mask bit, shows up in two ways. It leaves the wrong register contents once the move ends. It also changes the number of writes seen on `rf_we` before `done` rises. A cursor that advances early or late shifts every following pair, so a single run of a gather or scatter exposes it. A control state that fails to leave the run phase shows up as a missing or repeated `done`. It also appears as extra write strobes within a few cycles of the expected end, which the cycle-exact length check on unmasked copies and splats catches.

// File: rtl/vmove_pkg.sv
package vmove_pkg;

    localparam int unsigned XLEN_DEF  = 32;
    localparam int unsigned NREGS_DEF = 32;
    localparam int unsigned MAXVL_DEF = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // One cycle worth of sequencing decisions.
    typedef struct packed {
        logic rd;
        logic wr;
        logic src_adv;
        logic dst_adv;
        logic fin;
    } step_t;

    // Requested length folded into 1..maxv.
    function automatic int unsigned clamp_len(int unsigned v, int unsigned maxv);
        if (v == 0) return 1;
        if (v > maxv) return maxv;
        return v;
    endfunction

endpackage

// File: rtl/vmove_cursor.sv
module vmove_cursor #(
    parameter int unsigned AW    = 5,
    parameter int unsigned MAXVL = 8,
    parameter int unsigned VLW   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [AW-1:0]    base_i,
    input  logic             vec_i,
    input  logic             pen_i,
    input  logic [MAXVL-1:0] pred_i,
    input  logic [VLW-1:0]   len_i,
    output logic [AW-1:0]    addr,
    output logic             on,
    output logic             last,
    output logic             is_vec
);
    localparam int unsigned IW = (MAXVL > 1) ? $clog2(MAXVL) : 1;

    logic [AW-1:0]    base_q;
    logic             vec_q;
    logic [MAXVL-1:0] mask_q;
    logic [VLW-1:0]   len_q;
    logic [IW-1:0]    idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            vec_q  <= 1'b0;
            mask_q <= '1;
            len_q  <= VLW'(1);
            idx_q  <= '0;
        end else if (load) begin
            base_q <= base_i;
            vec_q  <= vec_i;
            // A scalar operand's mask has no meaning: treat it as all-on.
            mask_q <= (vec_i && pen_i) ? pred_i : '1;
            len_q  <= len_i;
            idx_q  <= '0;
        end else if (adv && !last) begin
            idx_q <= idx_q + IW'(1);
        end
    end

    assign addr   = base_q + AW'(idx_q);
    assign on     = mask_q[idx_q];
    assign last   = (VLW'(idx_q) == (len_q - VLW'(1)));
    assign is_vec = vec_q;

    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (adv && !last && !load) |=> (idx_q == $past(idx_q) + IW'(1)));

    p_scalar_still_r12: assert property (@(posedge clk) disable iff (rst)
        (!vec_q && !load) |-> !adv);

    p_idx_range_r8: assert property (@(posedge clk) disable iff (rst)
        VLW'(idx_q) < len_q);

endmodule

// File: rtl/vmove_ctrl.sv
module vmove_ctrl
    import vmove_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  s_on,
    input  logic  d_on,
    input  logic  s_last,
    input  logic  d_last,
    input  logic  s_vec,
    input  logic  d_vec,
    output logic  load,
    output logic  done,
    output step_t step
);
    seq_state_e state_q, state_d;
    logic       pair;

    always_comb begin
        pair = s_on && d_on;
        step = '0;
        if (state_q == ST_RUN) begin
            step.rd      = pair;
            step.wr      = pair;
            step.src_adv = s_vec && (pair || !s_on);
            step.dst_adv = d_vec && (pair || !d_on);
            step.fin     = (step.src_adv && s_last) ||
                           (step.dst_adv && d_last) ||
                           (!d_vec && pair);
        end
    end

    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_RUN;
                load    = 1'b1;
            end
            ST_RUN:  if (step.fin) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign done = (state_q == ST_DONE);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_run_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(state_q) == ST_RUN));

    p_scalar_dst_once_r4: assert property (@(posedge clk) disable iff (rst)
        (step.wr && !d_vec) |=> done);

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_RUN) |-> (!step.wr && !step.rd));

endmodule

// File: rtl/vmove_seq.sv
module vmove_seq
    import vmove_pkg::*;
#(
    parameter int unsigned XLEN  = XLEN_DEF,
    parameter int unsigned NREGS = NREGS_DEF,
    parameter int unsigned MAXVL = MAXVL_DEF,
    localparam int unsigned AW   = $clog2(NREGS),
    localparam int unsigned VLW  = $clog2(MAXVL + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic             src_vec,
    input  logic             dst_vec,
    input  logic             src_pred_en,
    input  logic [MAXVL-1:0] src_pred,
    input  logic             dst_pred_en,
    input  logic [MAXVL-1:0] dst_pred,
    input  logic [VLW-1:0]   vl,
    output logic             rf_re,
    output logic [AW-1:0]    rf_raddr,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             rf_we,
    output logic [AW-1:0]    rf_waddr,
    output logic [XLEN-1:0]  rf_wdata,
    output logic             done
);
    logic           load;
    step_t          step;
    logic           s_on, d_on, s_last, d_last, s_vec, d_vec;
    logic [VLW-1:0] len_eff;

    assign len_eff = VLW'(clamp_len(int'(unsigned'(vl)), MAXVL));

    vmove_cursor #(.AW(AW), .MAXVL(MAXVL), .VLW(VLW)) u_src (
        .clk(clk), .rst(rst), .load(load), .adv(step.src_adv),
        .base_i(src_base), .vec_i(src_vec), .pen_i(src_pred_en),
        .pred_i(src_pred), .len_i(len_eff),
        .addr(rf_raddr), .on(s_on), .last(s_last), .is_vec(s_vec)
    );

    vmove_cursor #(.AW(AW), .MAXVL(MAXVL), .VLW(VLW)) u_dst (
        .clk(clk), .rst(rst), .load(load), .adv(step.dst_adv),
        .base_i(dst_base), .vec_i(dst_vec), .pen_i(dst_pred_en),
        .pred_i(dst_pred), .len_i(len_eff),
        .addr(rf_waddr), .on(d_on), .last(d_last), .is_vec(d_vec)
    );

    vmove_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start),
        .s_on(s_on), .d_on(d_on), .s_last(s_last), .d_last(d_last),
        .s_vec(s_vec), .d_vec(d_vec),
        .load(load), .done(done), .step(step)
    );

    assign rf_re    = step.rd;
    assign rf_we    = step.wr;
    assign rf_wdata = rf_rdata;

    // No destination element is written twice in a row of a vector move.
    p_dst_fresh_r11: assert property (@(posedge clk) disable iff (rst)
        (rf_we && d_vec) |=> (!rf_we || rf_waddr != $past(rf_waddr)));

    // No source element is read twice in a vector move.
    p_src_fresh_r11: assert property (@(posedge clk) disable iff (rst)
        (rf_re && s_vec) |=> (!rf_re || rf_raddr != $past(rf_raddr)));

endmodule

// File: tb/sim_vmove_seq.sv
module sim_vmove_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [4:0]  src_base = '0, dst_base = '0;
    logic        src_vec = 1'b0, dst_vec = 1'b0;
    logic        src_pred_en = 1'b0, dst_pred_en = 1'b0;
    logic [7:0]  src_pred = '0, dst_pred = '0;
    logic [3:0]  vl = 4'd1;
    logic        rf_re, rf_we, done;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;

    logic [31:0] mem [NR];
    logic [31:0] exp_mem [NR];
    logic        init_req = 1'b0;
    logic [15:0] init_seed = '0;
    int          wcnt;
    int          checks = 0, fails = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vmove_seq u0 (
        .clk(clk), .rst(rst), .start(start),
        .src_base(src_base), .dst_base(dst_base),
        .src_vec(src_vec), .dst_vec(dst_vec),
        .src_pred_en(src_pred_en), .src_pred(src_pred),
        .dst_pred_en(dst_pred_en), .dst_pred(dst_pred), .vl(vl),
        .rf_re(rf_re), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .done(done)
    );

    assign rf_rdata = mem[rf_raddr];

    always @(posedge clk) begin
        if (init_req) begin
            for (int r = 0; r < NR; r++) mem[r] <= {8'hA5, init_seed, 3'b0, 5'(r)};
            wcnt <= 0;
        end else if (rf_we) begin
            mem[rf_waddr] <= rf_wdata;
            wcnt <= wcnt + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    // One full move with an independent list-pairing model.
    task automatic do_move(input bit sv, input bit dv, input bit spe, input logic [7:0] sp,
                           input bit dpe, input logic [7:0] dp, input int sb, input int db,
                           input int vreq, input bit poke, input int seed, input string extra);
        int ve, ns, nd, n, c, sl[8], dl[8], bad, bad_r;
        bit use_s, use_d;
        string tag;
        ve = (vreq == 0) ? 1 : (vreq > 8) ? 8 : vreq;
        use_s = sv && spe;
        use_d = dv && dpe;
        if (!sv && !dv)      tag = "R12";
        else if (!sv)        tag = use_d ? "R3" : "R2";
        else if (!dv)        tag = "R4";
        else if (!use_s && !use_d) tag = "R5";
        else if (use_s && !use_d)  tag = "R6";
        else                 tag = "R7";
        if ((vreq == 0 || vreq > 8) && (sv || dv)) tag = {tag, " R9"};
        tag = {tag, extra};

        init_seed = 16'(seed);
        init_req = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        for (int r = 0; r < NR; r++) exp_mem[r] = {8'hA5, 16'(seed), 3'b0, 5'(r)};

        ns = 0; nd = 0;
        if (sv) begin
            for (int i = 0; i < ve; i++) if (!use_s || sp[i]) begin sl[ns] = i; ns++; end
        end else ns = 99;
        if (dv) begin
            for (int i = 0; i < ve; i++) if (!use_d || dp[i]) begin dl[nd] = i; nd++; end
        end else begin nd = 1; dl[0] = 0; end
        n = (ns < nd) ? ns : nd;
        for (int k = 0; k < n; k++)
            exp_mem[(db + dl[k]) % NR] = exp_mem[(sb + (sv ? sl[k] : 0)) % NR];

        src_vec = sv; dst_vec = dv; src_pred_en = spe; dst_pred_en = dpe;
        src_pred = sp; dst_pred = dp; src_base = 5'(sb); dst_base = 5'(db); vl = 4'(vreq);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 1;
        while (!done && c < 64) begin
            if (poke && c == 2) begin
                start = 1'b1; src_base = 5'(sb + 3); dst_pred = ~dp; vl = 4'd8;
            end else start = 1'b0;
            @(negedge clk);
            c++;
        end
        start = 1'b0;
        chk(done == 1'b1, {tag, " R10 done seen"}, done, 1);
        if ((sv && dv && !use_s && !use_d) || (!sv && dv && !use_d))
            chk(c == ve + 1, {tag, " cycle count"}, c, ve + 1);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R10 done one cycle"}, done, 0);
        bad = 0; bad_r = 0;
        for (int r = 0; r < NR; r++) if (mem[r] !== exp_mem[r] && bad == 0) begin bad = 1; bad_r = r; end
        chk(bad == 0, {tag, " R8 R11 register contents"},
            mem[bad_r], exp_mem[bad_r]);
        chk(wcnt == n, {tag, " R11 write count"}, wcnt, n);
    endtask

    function automatic logic [7:0] pat(input int k, input int ve, input int seed);
        case (k)
            0: return 8'hFF;
            1: return 8'h00;
            2: return 8'(1) << ((ve + seed) % 8);
            default: return 8'((ve * 29 + seed * 53 + 7) ^ (seed * 3));
        endcase
    endfunction

    initial begin
        int run;
        run = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: quiet after reset
        chk(done == 1'b0, "R1 done after reset", done, 0);
        chk(rf_we == 1'b0, "R1 rf_we after reset", rf_we, 0);
        chk(rf_re == 1'b0, "R1 rf_re after reset", rf_re, 0);

        for (int f = 0; f < 16; f++)
            for (int v = 0; v < 10; v++)
                for (int k = 0; k < 4; k++) begin
                    int sb, db;
                    sb = (v * 3 + k * 7 + f) % NR;
                    db = (sb + 9 + k * 5 + f * 2) % NR;
                    do_move(f[3], f[2], f[1], pat(k, v, f + 1), f[0], pat((k + f) % 4, v, f + 5),
                            sb, db, v, 1'b0, run, "");
                    run++;
                end

        // R8: wrap around the end of the register file
        do_move(1, 1, 0, 8'h00, 0, 8'h00, 30, 27, 8, 1'b0, run, " R8 wrap"); run++;
        // R6: slide down inside one region (overlapping)
        do_move(1, 1, 1, 8'hFE, 0, 8'h00, 4, 4, 8, 1'b0, run, " slide"); run++;
        // R5: overlapping copy, destination one above source
        do_move(1, 1, 0, 8'h00, 0, 8'h00, 10, 11, 6, 1'b0, run, " overlap"); run++;
        // R3: insert into one element
        do_move(0, 1, 0, 8'h00, 1, 8'h20, 2, 16, 8, 1'b0, run, " insert"); run++;
        // R10: start and inputs changed mid-move are ignored
        do_move(1, 1, 1, 8'h5B, 1, 8'hB6, 3, 20, 8, 1'b1, run, " R10 busy start"); run++;
        do_move(0, 1, 0, 8'h00, 0, 8'h00, 7, 12, 5, 1'b1, run, " R10 busy start"); run++;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule